// File: doc/BRIEF.md
# Hit-Pattern Veto Lookup Table

This block classifies each detector hit pattern by looking it up in a programmable table. The table has 8192 entries of 4 bits. Each entry is indexed by a 13-bit pattern built from the 8 shield-pair discriminator bits and the 5 germanium local-trigger start bits. Software writes and reads entries one at a time through a 16-bit word port. Each table location takes one word, and the port address is the pattern itself.

At run time the stored entry for the current pattern is qualified by a delayed OR of the five germanium trigger outputs. The qualified bits drive the raw-germanium, clean-germanium and shield sumbus enables and a veto. A mode input sets how the veto is handled. In reject mode it raises the card inhibit. In mark mode it only flags the event. The germanium part of the pattern is latched, and it keeps its stale value while the card inhibit is active.

Top module: `clover_veto_lut`

## Requirements
- R1: After reset every table entry reads back as zero. Until an entry is written, its lookup drives no sumbus enable and no veto.
- R2: The pattern index carries the shield pairs s1..s8 in bits 0..7 and germanium A, B, C, D and spare in bits 8..12. `shield_hit[i]` feeds bit i and `ge_start[j]` feeds bit 8+j. The host address uses the same index.
- R3: A host write (`host_sel`=1, `host_we`=1) stores `host_wdata[3:0]` and ignores bits 15..4. A host read presents `{12'b0, entry}` on `host_rdata` after the clock edge that samples `host_addr`.
- R4: Entry bit 0 is veto, bit 1 is raw-germanium enable, bit 2 is clean-germanium enable and bit 3 is shield enable.
- R5: A pattern present at clock edge k produces its outputs after edge k+1.
- R6: Outputs are driven only while the OR of `ge_trig`, delayed by TRIG_DLY (default 2) edges, is high. A trigger seen at a single edge k qualifies the outputs only between edges k+1 and k+2.
- R7: In mark mode (`reject_mode`=0), a qualified veto raises `event_mark` and does not affect `card_inhibit`.
- R8: In reject mode (`reject_mode`=1), a qualified veto raises `card_inhibit` and keeps `event_mark` low.
- R9: `ext_inhibit` raises `card_inhibit` in the same cycle, in either mode.
- R10: While `card_inhibit` is high, the germanium bits of the sampled pattern hold their last value. The shield bits keep following `shield_hit`.
- R11: A host write at edge k is seen by a lookup whose pattern is sampled at edge k or later. Host reads run alongside lookups without stalling either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write when set with host_sel |
| host_addr | input | 13 | Table index (hit pattern) |
| host_wdata | input | 16 | Host write word; bits 3..0 are stored |
| host_rdata | output | 16 | Entry at the previous cycle's host_addr, zero-extended |
| shield_hit | input | 8 | Shield-pair discriminator bits s1..s8 |
| ge_start | input | 5 | Germanium local-trigger start bits A..D, spare |
| ge_trig | input | 5 | Germanium trigger outputs, ORed and delayed |
| reject_mode | input | 1 | 1 = reject, 0 = mark |
| ext_inhibit | input | 1 | System inhibit request |
| raw_en | output | 1 | Raw germanium sumbus enable |
| clean_en | output | 1 | Clean germanium sumbus enable |
| shield_en | output | 1 | Shield sumbus enable |
| event_mark | output | 1 | Veto flagged in mark mode |
| card_inhibit | output | 1 | Card-level inhibit |

## Verification
The bench fills every one of the 8192 entries from an arithmetic rule, reads each one back, and then looks up every pattern with the trigger on. A swapped index bit, a dropped packing lane or a misplaced entry bit therefore shows up as a mismatch on some pattern. A single-cycle trigger pulse is checked one cycle too early, on time and one cycle late, which catches an off-by-one delay line. The inhibit tests change `ge_start` while the card is inhibited: a design that failed to freeze the germanium bits, or that froze the shield bits as well, would look up the wrong entry. A write made in the same cycle as the lookup of that pattern must return the new value, and a design missing the per-word fresh flag would return stale or undefined entries after reset.

// File: rtl/clover_veto_pkg.sv
package clover_veto_pkg;
    localparam int SHIELD_BITS = 8;
    localparam int GE_BITS     = 5;
    localparam int ENTRY_BITS  = 4;
    localparam int HOST_BITS   = 16;

    // bit 3 shield, bit 2 clean, bit 1 raw, bit 0 veto
    typedef struct packed {
        logic shield_en;
        logic clean_en;
        logic raw_en;
        logic veto;
    } veto_entry_t;

    function automatic veto_entry_t qualify(input veto_entry_t e, input logic gate);
        return gate ? e : '0;
    endfunction
endpackage

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (DLY == 0) begin : g_pass
            assign q = d;
        end else begin : g_shift
            logic [DLY-1:0] stage;
            always_ff @(posedge clk) begin
                if (rst) stage <= '0;
                else     stage <= DLY'({stage, d});
            end
            assign q = stage[DLY-1];
        end
    endgenerate
endmodule

// File: rtl/veto_table_store.sv
module veto_table_store #(
    parameter int PAT_W    = 13,
    parameter int ENT_W    = 4,
    parameter int PACK_LOG = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PAT_W-1:0] wr_addr,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [PAT_W-1:0] a_addr,
    output logic [ENT_W-1:0] a_data,
    input  logic [PAT_W-1:0] b_addr,
    output logic [ENT_W-1:0] b_data
);
    localparam int WORD_AW = PAT_W - PACK_LOG;
    localparam int WORDS   = 1 << WORD_AW;
    localparam int WORD_W  = ENT_W << PACK_LOG;

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  fresh;   // set once a word has been written since reset

    logic [WORD_AW-1:0]  wa;
    logic [PACK_LOG-1:0] wl;
    assign wa = wr_addr[PAT_W-1:PACK_LOG];
    assign wl = wr_addr[PACK_LOG-1:0];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (fresh[wa]) mem[wa][int'(wl)*ENT_W +: ENT_W] <= wr_data;
            else           mem[wa] <= WORD_W'(wr_data) << (int'(wl)*ENT_W);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        fresh <= '0;
        else if (wr_en) fresh[wa] <= 1'b1;
    end

    logic [ENT_W-1:0] a_next, b_next;
    always_comb begin
        a_next = '0;
        b_next = '0;
        if (fresh[a_addr[PAT_W-1:PACK_LOG]])
            a_next = mem[a_addr[PAT_W-1:PACK_LOG]][int'(a_addr[PACK_LOG-1:0])*ENT_W +: ENT_W];
        if (fresh[b_addr[PAT_W-1:PACK_LOG]])
            b_next = mem[b_addr[PAT_W-1:PACK_LOG]][int'(b_addr[PACK_LOG-1:0])*ENT_W +: ENT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_data <= '0;
            b_data <= '0;
        end else begin
            a_data <= a_next;
            b_data <= b_next;
        end
    end

    assert_clear_R1: assert property (@(posedge clk) rst |=> (a_data == '0 && b_data == '0));
endmodule

// File: rtl/clover_veto_lut.sv
module clover_veto_lut
    import clover_veto_pkg::*;
#(
    parameter int SHIELD_W = SHIELD_BITS,
    parameter int GE_W     = GE_BITS,
    parameter int HOST_W   = HOST_BITS,
    parameter int TRIG_DLY = 2,
    parameter int PACK_LOG = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       host_sel,
    input  logic                       host_we,
    input  logic [SHIELD_W+GE_W-1:0]   host_addr,
    input  logic [HOST_W-1:0]          host_wdata,
    output logic [HOST_W-1:0]          host_rdata,
    input  logic [SHIELD_W-1:0]        shield_hit,
    input  logic [GE_W-1:0]            ge_start,
    input  logic [GE_W-1:0]            ge_trig,
    input  logic                       reject_mode,
    input  logic                       ext_inhibit,
    output logic                       raw_en,
    output logic                       clean_en,
    output logic                       shield_en,
    output logic                       event_mark,
    output logic                       card_inhibit
);
    localparam int PAT_W = SHIELD_W + GE_W;
    localparam int ENT_W = ENTRY_BITS;

    logic [SHIELD_W-1:0] shield_q;
    logic [GE_W-1:0]     ge_q;
    logic [PAT_W-1:0]    pat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shield_q <= '0;
            ge_q     <= '0;
        end else begin
            shield_q <= shield_hit;
            if (!card_inhibit) ge_q <= ge_start;
        end
    end
    assign pat_q = {ge_q, shield_q};

    logic [ENT_W-1:0] host_ent, look_ent;
    logic             unused_wdata_hi;
    assign unused_wdata_hi = ^host_wdata[HOST_W-1:ENT_W];

    veto_table_store #(.PAT_W(PAT_W), .ENT_W(ENT_W), .PACK_LOG(PACK_LOG)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_sel && host_we),
        .wr_addr (host_addr),
        .wr_data (host_wdata[ENT_W-1:0]),
        .a_addr  (host_addr),
        .a_data  (host_ent),
        .b_addr  (pat_q),
        .b_data  (look_ent)
    );
    assign host_rdata = HOST_W'(host_ent);

    logic trig_dly;
    trig_delay_line #(.DLY(TRIG_DLY)) u_trig (
        .clk (clk),
        .rst (rst),
        .d   (|ge_trig),
        .q   (trig_dly)
    );

    veto_entry_t live;
    assign live         = qualify(veto_entry_t'(look_ent), trig_dly);
    assign raw_en       = live.raw_en;
    assign clean_en     = live.clean_en;
    assign shield_en    = live.shield_en;
    assign event_mark   = live.veto && !reject_mode;
    assign card_inhibit = ext_inhibit || (live.veto && reject_mode);

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> !(raw_en || clean_en || shield_en || event_mark));
    assert_ge_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        card_inhibit |=> $stable(ge_q));
    assert_mark_no_inhibit_R7: assert property (@(posedge clk) disable iff (rst)
        event_mark |-> (!card_inhibit || ext_inhibit));
    assert_reject_no_mark_R8: assert property (@(posedge clk) disable iff (rst)
        event_mark |-> !reject_mode);
endmodule

// File: tb/clover_veto_lut_tb.sv
module clover_veto_lut_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPAT = 8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0, host_we = 1'b0;
    logic [12:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [7:0]  shield_hit = '0;
    logic [4:0]  ge_start = '0, ge_trig = '0;
    logic        reject_mode = 1'b0, ext_inhibit = 1'b0;
    logic        raw_en, clean_en, shield_en, event_mark, card_inhibit;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clover_veto_lut u_dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .shield_hit(shield_hit), .ge_start(ge_start), .ge_trig(ge_trig),
        .reject_mode(reject_mode), .ext_inhibit(ext_inhibit),
        .raw_en(raw_en), .clean_en(clean_en), .shield_en(shield_en),
        .event_mark(event_mark), .card_inhibit(card_inhibit)
    );

    function automatic logic [3:0] ent_of(input int p);
        return 4'((p * 7) ^ (p >> 8) ^ (p >> 3));
    endfunction

    function automatic logic [4:0] outs_exp(input logic [3:0] e, input bit rej, input bit ext);
        // {shield, clean, raw, mark, inhibit}
        return {e[3], e[2], e[1], e[0] & ~rej, ext | (e[0] & rej)};
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] outs_now();
        return 16'({shield_en, clean_en, raw_en, event_mark, card_inhibit});
    endfunction

    task automatic host_write(input int p, input logic [3:0] v);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = 13'(p);
        host_wdata = {12'(p * 3 + 1), v};
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read_chk(input int p, input logic [3:0] v, input string tag);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b0; host_addr = 13'(p);
        @(negedge clk);
        check(host_rdata, {12'b0, v}, tag);
        host_sel = 1'b0;
    endtask

    task automatic set_pat(input int p, input bit trig);
        shield_hit = p[7:0];
        ge_start   = p[12:8];
        ge_trig    = trig ? 5'(1 << (p % 5)) : 5'b0;
    endtask

    task automatic lookup_chk(input int p, input bit trig, input logic [3:0] e, input string tag);
        @(negedge clk);
        set_pat(p, trig);
        @(negedge clk);
        @(negedge clk);
        check(outs_now(), 16'(outs_exp(trig ? e : 4'b0, reject_mode, ext_inhibit)), tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int p_v, p_n, p_a, gev, s2, g2, p_w;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(outs_now(), 16'h0, "R1 outputs after reset");
        host_read_chk(0, 4'h0, "R1 entry 0 cleared");
        host_read_chk(8191, 4'h0, "R1 entry 8191 cleared");
        host_read_chk(1234, 4'h0, "R1 entry 1234 cleared");
        lookup_chk(8191, 1'b1, 4'h0, "R1 lookup unloaded entry");

        // R3: fill whole table with upper garbage bits, read all back
        for (int p = 0; p < NPAT; p++) host_write(p, ent_of(p));
        for (int p = 0; p < NPAT; p++) host_read_chk(p, ent_of(p), "R3 readback");

        // R2 R4 R5: exhaustive lookup sweep in mark mode
        for (int p = 0; p < NPAT; p++) lookup_chk(p, 1'b1, ent_of(p), "R2 R4 R5 sweep");

        // R6: no trigger, no outputs
        for (int p = 100; p < 116; p++) lookup_chk(p, 1'b0, ent_of(p), "R6 untriggered");

        // pick patterns
        p_v = 0; p_n = 0;
        for (int p = 1; p < NPAT; p++) if (ent_of(p)[0] && ent_of(p)[3:1] != 0 && p_v == 0) p_v = p;
        for (int p = 1; p < NPAT; p++) if (!ent_of(p)[0] && ent_of(p)[3:1] != 0 && p_n == 0) p_n = p;

        // R6: single-cycle trigger pulse timing
        @(negedge clk); set_pat(p_n, 1'b0);
        repeat (3) @(negedge clk);
        ge_trig = 5'b00100;
        @(negedge clk); ge_trig = 5'b0;
        check(outs_now(), 16'h0, "R6 pulse not yet");
        @(negedge clk);
        check(outs_now(), 16'(outs_exp(ent_of(p_n), 1'b0, 1'b0)), "R6 pulse on time");
        @(negedge clk);
        check(outs_now(), 16'h0, "R6 pulse gone");

        // R7: mark mode veto flags only
        lookup_chk(p_v, 1'b1, ent_of(p_v), "R7 mark veto");

        // R8: reject mode
        @(negedge clk); reject_mode = 1'b1;
        lookup_chk(p_n, 1'b1, ent_of(p_n), "R8 reject no veto");
        lookup_chk(p_v, 1'b1, ent_of(p_v), "R8 reject veto inhibits");

        // R10: germanium bits frozen while inhibited, shield bits not
        gev = p_v >> 8;
        g2  = (gev + 1) & 31;
        @(negedge clk); ge_start = 5'(g2);
        @(negedge clk); @(negedge clk);
        check(outs_now(), 16'(outs_exp(ent_of(p_v), 1'b1, 1'b0)), "R10 stale ge held");
        s2 = ((p_v & 255) + 17) & 255;
        @(negedge clk); shield_hit = 8'(s2);
        @(negedge clk); @(negedge clk);
        check(outs_now(), 16'(outs_exp(ent_of((gev << 8) | s2), 1'b1, 1'b0)), "R10 shield follows");

        // R9: external inhibit, mark mode, freezes ge bits too
        @(negedge clk); reject_mode = 1'b0;
        p_a = p_n;
        lookup_chk(p_a, 1'b1, ent_of(p_a), "R9 setup");
        @(negedge clk); ext_inhibit = 1'b1; ge_start = 5'((p_a >> 8) ^ 5'h15);
        #1 check(16'(card_inhibit), 16'h1, "R9 inhibit immediate");
        @(negedge clk); @(negedge clk);
        check(outs_now(), 16'(outs_exp(ent_of(p_a), 1'b0, 1'b1)), "R9 R10 ext freeze");
        @(negedge clk); ext_inhibit = 1'b0;
        #1 check(16'(card_inhibit), 16'h0, "R9 inhibit released");

        // R11: write in same cycle as lookup sample, plus concurrent host read
        p_w = 4321;
        @(negedge clk);
        set_pat(p_w, 1'b1);
        host_sel = 1'b1; host_we = 1'b1; host_addr = 13'(p_w); host_wdata = 16'hFFF0 | 16'(~ent_of(p_w));
        @(negedge clk);
        host_we = 1'b0; host_addr = 13'(p_v);
        @(negedge clk);
        host_sel = 1'b0;
        check(outs_now(), 16'(outs_exp(~ent_of(p_w), 1'b0, 1'b0)), "R11 new entry seen");
        check(host_rdata, {12'b0, ent_of(p_v)}, "R11 concurrent host read");
        host_read_chk(p_w, ~ent_of(p_w), "R11 readback rewritten");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule